// File: doc/BRIEF.md
# Indirect Configuration Port Decoder

This block is the host-bridge end of an indirect configuration mechanism. Software first writes a 32-bit configuration address to a fixed I/O address port. It then reads or writes a nearby data port. The block holds the address in a register that can be read back. When that register's enable bit is set, each data-port access becomes one configuration request on a downstream target interface. The request carries the bus number, the device/function number, the dword register index and the byte enables derived from the I/O access.

The I/O side uses byte addresses. The access size is given as byte, word or dword, and data is right-justified on the I/O bus. The block moves write data into the correct byte lanes of the selected dword, and shifts read data from the target back to bit 0. Narrow accesses that land on the address port are not treated as register loads. They are forwarded unchanged to a legacy I/O path, so code that touches single bytes there still reaches older hardware. Each request carries a flag that tells the downstream logic whether the request is for the local bus (bus 0) or must be forwarded to another bus.

Top module: `cfgp_bridge`

## Requirements
- R1: After reset the configuration address register reads as 0x00000000, and io_done, tgt_req and lg_req are low.
- R2: Only a dword write (io_size=2) at the address port (0xCF8) loads the address register, with enable = bit 31, bus = bits 23:16, device/function = bits 15:8 and register index = bits 7:2. A dword read returns these fields in the same positions, with bits 30:24 and 1:0 reading as zero. After 0x80000000 is written, a read returns exactly 0x80000000. An address-port access raises io_done one cycle after it is accepted.
- R3: A byte or word access (io_size 0 or 1) anywhere in 0xCF8..0xCFB leaves the address register unchanged. It raises lg_req for one cycle, passing the address, size, direction and write data through unchanged. It completes one cycle after lg_ack, and a read returns lg_rdata as it is.
- R4: A data-port access while the enable bit is set raises tgt_req for exactly one cycle. tgt_bus, tgt_devfn and tgt_reg carry the latched address fields, and tgt_wr carries the direction.
- R5: A byte access at 0xCFC+n drives tgt_be = 1<<n. A write places data byte 0 into lane n of tgt_wdata. A read returns lane n of tgt_rdata in bits 7:0, with the upper bits zero.
- R6: A word access at 0xCFC or 0xCFE drives tgt_be = 4'b0011 or 4'b1100, and moves the 16-bit data between bits 15:0 of the I/O bus and the low or high half of the dword.
- R7: A dword access at 0xCFC drives tgt_be = 4'b1111 and passes all 32 bits unchanged in both directions.
- R8: tgt_type1 is 0 when tgt_bus is 0, and 1 for any other bus number.
- R9: A target-path access raises io_done for one cycle, one cycle after tgt_ack is sampled high, and no earlier. tgt_req is not raised again while the block waits for the ack.
- R10: While the enable bit is clear, a data-port read returns 0xFFFFFFFF and a data-port write is dropped. In both cases there is no tgt_req, and io_done follows one cycle after the access is accepted.
- R11: A misaligned data-port access is handled like R10. This covers a word at an odd offset and a dword at a nonzero offset.
- R12: Writing back a value previously read from the address port restores the address register, and later requests use the restored fields.
- R13: An access to an address outside 0xCF8..0xCFF produces no io_done, no tgt_req and no lg_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | AW | I/O byte address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword |
| io_rd | input | 1 | Read request, held until io_done |
| io_wr | input | 1 | Write request, held until io_done |
| io_wdata | input | 32 | Right-justified write data |
| io_rdata | output | 32 | Right-justified read data, valid with io_done |
| io_done | output | 1 | One-cycle completion pulse |
| tgt_req | output | 1 | One-cycle configuration request strobe |
| tgt_wr | output | 1 | Request is a write |
| tgt_bus | output | 8 | Bus number |
| tgt_devfn | output | 8 | Device/function number |
| tgt_reg | output | 6 | Dword register index |
| tgt_be | output | 4 | Byte enables within the dword |
| tgt_type1 | output | 1 | Request is for a bus other than 0 |
| tgt_wdata | output | 32 | Lane-placed write data |
| tgt_rdata | input | 32 | Target read dword, valid with tgt_ack |
| tgt_ack | input | 1 | Target completion |
| lg_req | output | 1 | One-cycle legacy access strobe |
| lg_wr | output | 1 | Legacy access is a write |
| lg_addr | output | AW | Legacy access address |
| lg_size | output | 2 | Legacy access size |
| lg_wdata | output | 32 | Legacy write data |
| lg_rdata | input | 32 | Legacy read data, valid with lg_ack |
| lg_ack | input | 1 | Legacy completion |

## Verification
The hardest state to reach from the ports is a byte access to the address port that must leave the latched address intact while still being forwarded. This looks like a register update but must not be one. The stimulus first loads a known enabled address and writes a byte at the top of the address port. It then checks both the forwarded legacy fields and a full dword readback. Data-port lane steering is driven from a vector table. The target model returns a dword built from the request's own fields, so every byte lane carries a distinct value, and it acknowledges after a delay that changes from access to access.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int CFG_BUS_W   = 8;
  localparam int CFG_DEVFN_W = 8;
  localparam int CFG_REG_W   = 6;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  typedef enum logic [2:0] {
    AC_NONE, AC_AREG, AC_LEGACY, AC_DATA, AC_DROP
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TREQ, ST_TWAIT, ST_LREQ, ST_LWAIT, ST_DONE
  } fsm_e;

  // Mask of the valid right-justified data bits for an access size.
  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_WORD: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // True when the access size fits its byte offset inside the dword.
  function automatic logic lane_ok(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE:  lane_ok = 1'b1;
      SZ_WORD:  lane_ok = (off[0] == 1'b0);
      SZ_DWORD: lane_ok = (off == 2'd0);
      default:  lane_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: lane_be = 4'b0001 << off;
      SZ_WORD: lane_be = 4'b0011 << off;
      default: lane_be = 4'b1111;
    endcase
  endfunction

  // Right-justified I/O data moved into its byte lanes.
  function automatic logic [31:0] place(input logic [31:0] w, input logic [1:0] sz,
                                        input logic [1:0] off);
    place = (w & size_mask(sz)) << {off, 3'b000};
  endfunction

  // Lane data from the dword moved back to bit 0.
  function automatic logic [31:0] pick(input logic [31:0] r, input logic [1:0] sz,
                                       input logic [1:0] off);
    pick = (r >> {off, 3'b000}) & size_mask(sz);
  endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  ADDR_PORT = 16'h0CF8,
  parameter logic [AW-1:0]  DATA_PORT = 16'h0CFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [1:0]    io_size,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic          cfg_en,
  output acc_e          kind,
  output logic [3:0]    be
);

  logic       active;
  logic       at_aport;
  logic       at_dport;
  logic [1:0] off;

  assign active   = io_rd | io_wr;
  assign off      = io_addr[1:0];
  assign at_aport = (io_addr[AW-1:2] == ADDR_PORT[AW-1:2]);
  assign at_dport = (io_addr[AW-1:2] == DATA_PORT[AW-1:2]);
  assign be       = lane_be(io_size, off);

  always_comb begin
    kind = AC_NONE;
    if (active) begin
      if (at_aport) begin
        kind = (io_size == SZ_DWORD && off == 2'd0) ? AC_AREG : AC_LEGACY;
      end else if (at_dport) begin
        kind = (cfg_en && lane_ok(io_size, off)) ? AC_DATA : AC_DROP;
      end
    end
  end

  // R5/R6/R7: a forwarded access always has a contiguous, size-matched lane set
  a_r5_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == AC_DATA) |-> (be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                      4'b0011, 4'b1100, 4'b1111}));

  // R11: a misaligned data-port access is never forwarded
  a_r11_no_misaligned_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (at_dport && active && io_size == SZ_WORD && off[0]) |-> (kind == AC_DROP));

endmodule

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld,
  input  logic [31:0]            wdata,
  output logic                   en,
  output logic [CFG_BUS_W-1:0]   bus,
  output logic [CFG_DEVFN_W-1:0] devfn,
  output logic [CFG_REG_W-1:0]   regno,
  output logic [31:0]            image
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      bus   <= '0;
      devfn <= '0;
      regno <= '0;
    end else if (ld) begin
      en    <= wdata[31];
      bus   <= wdata[23:16];
      devfn <= wdata[15:8];
      regno <= wdata[7:2];
    end
  end

  assign image = {en, 7'b0, bus, devfn, regno, 2'b00};

  // R3: without a dword load the latched address never moves
  a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(image));

  // R2: a load is visible in the readback image on the next cycle
  a_r2_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (image[31] == $past(wdata[31]) && image[23:2] == $past(wdata[23:2])));

endmodule

// File: rtl/cfgp_bridge.sv
module cfgp_bridge
  import cfgp_pkg::*;
#(
  parameter int             AW        = 16,
  parameter logic [AW-1:0]  ADDR_PORT = 16'h0CF8,
  parameter logic [AW-1:0]  DATA_PORT = 16'h0CFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [1:0]    io_size,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [31:0]   io_wdata,
  output logic [31:0]   io_rdata,
  output logic          io_done,
  output logic          tgt_req,
  output logic          tgt_wr,
  output logic [7:0]    tgt_bus,
  output logic [7:0]    tgt_devfn,
  output logic [5:0]    tgt_reg,
  output logic [3:0]    tgt_be,
  output logic          tgt_type1,
  output logic [31:0]   tgt_wdata,
  input  logic [31:0]   tgt_rdata,
  input  logic          tgt_ack,
  output logic          lg_req,
  output logic          lg_wr,
  output logic [AW-1:0] lg_addr,
  output logic [1:0]    lg_size,
  output logic [31:0]   lg_wdata,
  input  logic [31:0]   lg_rdata,
  input  logic          lg_ack
);

  acc_e                   kind;
  logic [3:0]             dec_be;
  logic                   cfg_en;
  logic [CFG_BUS_W-1:0]   cfg_bus;
  logic [CFG_DEVFN_W-1:0] cfg_devfn;
  logic [CFG_REG_W-1:0]   cfg_regno;
  logic [31:0]            cfg_image;
  logic                   areg_ld;
  fsm_e                   state;
  logic [1:0]             size_q;
  logic [1:0]             off_q;
  logic                   done_tgt;

  // Named events for the assertions
  logic                   ev_accept;
  logic                   ev_tgt_ack;

  cfgp_decode #(.AW(AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .io_addr(io_addr),
    .io_size(io_size),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .cfg_en (cfg_en),
    .kind   (kind),
    .be     (dec_be)
  );

  cfgp_addr_reg u_areg (
    .clk  (clk),
    .rst_n(rst_n),
    .ld   (areg_ld),
    .wdata(io_wdata),
    .en   (cfg_en),
    .bus  (cfg_bus),
    .devfn(cfg_devfn),
    .regno(cfg_regno),
    .image(cfg_image)
  );

  assign ev_accept  = (state == ST_IDLE) && (kind != AC_NONE);
  assign ev_tgt_ack = ((state == ST_TREQ) || (state == ST_TWAIT)) && tgt_ack;
  assign areg_ld    = (state == ST_IDLE) && (kind == AC_AREG) && io_wr;

  assign tgt_req = (state == ST_TREQ);
  assign lg_req  = (state == ST_LREQ);
  assign io_done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      io_rdata  <= '0;
      size_q    <= '0;
      off_q     <= '0;
      done_tgt  <= 1'b0;
      tgt_wr    <= 1'b0;
      tgt_bus   <= '0;
      tgt_devfn <= '0;
      tgt_reg   <= '0;
      tgt_be    <= '0;
      tgt_type1 <= 1'b0;
      tgt_wdata <= '0;
      lg_wr     <= 1'b0;
      lg_addr   <= '0;
      lg_size   <= '0;
      lg_wdata  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          done_tgt <= 1'b0;
          case (kind)
            AC_AREG: begin
              io_rdata <= cfg_image;
              state    <= ST_DONE;
            end
            AC_LEGACY: begin
              lg_wr    <= io_wr;
              lg_addr  <= io_addr;
              lg_size  <= io_size;
              lg_wdata <= io_wdata;
              state    <= ST_LREQ;
            end
            AC_DATA: begin
              tgt_wr    <= io_wr;
              tgt_bus   <= cfg_bus;
              tgt_devfn <= cfg_devfn;
              tgt_reg   <= cfg_regno;
              tgt_be    <= dec_be;
              tgt_type1 <= (cfg_bus != '0);
              tgt_wdata <= place(io_wdata, io_size, io_addr[1:0]);
              size_q    <= io_size;
              off_q     <= io_addr[1:0];
              state     <= ST_TREQ;
            end
            AC_DROP: begin
              io_rdata <= '1;
              state    <= ST_DONE;
            end
            default: state <= ST_IDLE;
          endcase
        end
        ST_TREQ, ST_TWAIT: begin
          if (tgt_ack) begin
            io_rdata <= pick(tgt_rdata, size_q, off_q);
            done_tgt <= 1'b1;
            state    <= ST_DONE;
          end else begin
            state <= ST_TWAIT;
          end
        end
        ST_LREQ, ST_LWAIT: begin
          if (lg_ack) begin
            io_rdata <= lg_rdata;
            state    <= ST_DONE;
          end else begin
            state <= ST_LWAIT;
          end
        end
        default: begin
          done_tgt <= 1'b0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  // R4: the request strobe lasts exactly one cycle
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |=> !tgt_req);

  // R4: request fields agree with the latched configuration address
  a_r4_fields_match: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> (tgt_bus == cfg_bus && tgt_devfn == cfg_devfn && tgt_reg == cfg_regno));

  // R3: the legacy strobe lasts exactly one cycle
  a_r3_lg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lg_req |=> !lg_req);

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |=> !io_done);

  // R9: a target-path completion follows a sampled ack
  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (io_done && done_tgt) |-> $past(ev_tgt_ack));

  // R10: with the enable bit clear no request is launched
  a_r10_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !cfg_en) |=> !tgt_req);

endmodule

// File: tb/cfgp_bridge_bench.sv
`timescale 1ns/1ps
module cfgp_bridge_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_done;
  logic        tgt_req, tgt_wr, tgt_type1;
  logic [7:0]  tgt_bus, tgt_devfn;
  logic [5:0]  tgt_reg;
  logic [3:0]  tgt_be;
  logic [31:0] tgt_wdata;
  logic [31:0] tgt_rdata = '0;
  logic        tgt_ack = 1'b0;
  logic        lg_req, lg_wr;
  logic [15:0] lg_addr;
  logic [1:0]  lg_size;
  logic [31:0] lg_wdata;
  logic [31:0] lg_rdata = '0;
  logic        lg_ack = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int tgt_delay = 0;

  // captured at the request strobe
  logic        c_wr, c_type1, c_lwr;
  logic [7:0]  c_bus, c_devfn;
  logic [5:0]  c_reg;
  logic [3:0]  c_be;
  logic [31:0] c_wdata, c_lwdata;
  logic [15:0] c_laddr;
  logic [1:0]  c_lsize;

  always #2.5 clk = ~clk;

  cfgp_bridge u_cfgp_bridge (
    .clk(clk), .rst_n(rst_n),
    .io_addr(io_addr), .io_size(io_size), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_done(io_done),
    .tgt_req(tgt_req), .tgt_wr(tgt_wr), .tgt_bus(tgt_bus), .tgt_devfn(tgt_devfn),
    .tgt_reg(tgt_reg), .tgt_be(tgt_be), .tgt_type1(tgt_type1), .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata), .tgt_ack(tgt_ack),
    .lg_req(lg_req), .lg_wr(lg_wr), .lg_addr(lg_addr), .lg_size(lg_size),
    .lg_wdata(lg_wdata), .lg_rdata(lg_rdata), .lg_ack(lg_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Target model: read dword built from the request fields
  initial begin
    forever begin
      @(negedge clk);
      if (tgt_req) begin
        repeat (tgt_delay) @(negedge clk);
        tgt_rdata = {tgt_bus, tgt_devfn, tgt_reg, 2'b00, 8'h5A};
        tgt_ack = 1'b1;
        @(negedge clk);
        tgt_ack = 1'b0;
      end
    end
  end

  // Legacy model
  initial begin
    forever begin
      @(negedge clk);
      if (lg_req) begin
        repeat (2) @(negedge clk);
        lg_rdata = 32'hA1B2_C3D4;
        lg_ack = 1'b1;
        @(negedge clk);
        lg_ack = 1'b0;
      end
    end
  end

  // One I/O cycle: returns read data, request counts, and req-to-done latency.
  task automatic do_io(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output int nreq, output int nlg, output int lat);
    bit got;
    int req_at;
    @(negedge clk);
    io_addr = a; io_size = sz; io_wdata = wd; io_wr = wr; io_rd = !wr;
    nreq = 0; nlg = 0; lat = -1; got = 0; req_at = -1; rd = 'x;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk);
      if (tgt_req) begin
        nreq++; req_at = i;
        c_wr = tgt_wr; c_bus = tgt_bus; c_devfn = tgt_devfn; c_reg = tgt_reg;
        c_be = tgt_be; c_type1 = tgt_type1; c_wdata = tgt_wdata;
      end
      if (lg_req) begin
        nlg++;
        c_lwr = lg_wr; c_laddr = lg_addr; c_lsize = lg_size; c_lwdata = lg_wdata;
      end
      if (io_done) begin
        got = 1; rd = io_rdata;
        if (req_at >= 0) lat = i - req_at;
      end
    end
    if (!got) chk("io-cycle watchdog (R9)", 32'd0, 32'd1);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  // wr off size wdata be twdata rdata
  localparam int NV = 10;
  localparam logic [104:0] VEC [NV] = '{
    {1'b0, 2'd0, 2'd0, 32'h0, 4'h1, 32'h0, 32'h0000_005A},
    {1'b0, 2'd1, 2'd0, 32'h0, 4'h2, 32'h0, 32'h0000_0044},
    {1'b0, 2'd2, 2'd0, 32'h0, 4'h4, 32'h0, 32'h0000_0029},
    {1'b0, 2'd3, 2'd0, 32'h0, 4'h8, 32'h0, 32'h0000_0003},
    {1'b0, 2'd0, 2'd1, 32'h0, 4'h3, 32'h0, 32'h0000_445A},
    {1'b0, 2'd2, 2'd1, 32'h0, 4'hC, 32'h0, 32'h0000_0329},
    {1'b0, 2'd0, 2'd2, 32'h0, 4'hF, 32'h0, 32'h0329_445A},
    {1'b1, 2'd1, 2'd0, 32'hFFFF_FFBE, 4'h2, 32'h0000_BE00, 32'h0},
    {1'b1, 2'd2, 2'd1, 32'h1111_CAFE, 4'hC, 32'hCAFE_0000, 32'h0},
    {1'b1, 2'd0, 2'd2, 32'h1234_5678, 4'hF, 32'h1234_5678, 32'h0}
  };

  initial begin
    logic [31:0] rd, saved;
    int nreq, nlg, lat, nd, nr, nl;

    fork
      begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 io_done", {31'b0, io_done}, 32'd0);
    chk("R1 tgt_req", {31'b0, tgt_req}, 32'd0);
    chk("R1 lg_req",  {31'b0, lg_req},  32'd0);
    rst_n = 1'b1;
    do_io(0, 16'h0CF8, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R1 address reg after reset", rd, 32'h0);

    // R2: enable-only readback, R8: bus 0 is type 0
    do_io(1, 16'h0CF8, 2'd2, 32'h8000_0000, rd, nreq, nlg, lat);
    do_io(0, 16'h0CF8, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R2 readback 0x80000000", rd, 32'h8000_0000);
    do_io(0, 16'h0CFC, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R8 bus0 type flag", {31'b0, c_type1}, 32'd0);
    chk("R7 bus0 dword read", rd, 32'h0000_005A);

    // R2: reserved bits read zero
    do_io(1, 16'h0CF8, 2'd2, 32'hFFFF_FFFF, rd, nreq, nlg, lat);
    do_io(0, 16'h0CF8, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R2 reserved bits zero", rd, 32'h80FF_FFFC);

    // Main configuration: bus 3, devfn 0x29, register 0x11
    do_io(1, 16'h0CF8, 2'd2, 32'h8003_2944, rd, nreq, nlg, lat);
    for (int v = 0; v < NV; v++) begin
      logic [104:0] e;
      e = VEC[v];
      tgt_delay = v % 3;
      do_io(e[104], 16'h0CFC + {14'b0, e[103:102]}, e[101:100], e[99:68],
            rd, nreq, nlg, lat);
      chk("R4 one request", nreq, 1);
      chk("R4 direction", {31'b0, c_wr}, {31'b0, e[104]});
      chk("R4 bus/devfn/reg", {10'b0, c_bus, c_devfn, c_reg}, {10'b0, 8'h03, 8'h29, 6'h11});
      chk("R5/R6/R7 byte enables", {28'b0, c_be}, {28'b0, e[67:64]});
      chk("R8 nonzero bus type flag", {31'b0, c_type1}, 32'd1);
      chk("R9 ack to done latency", lat, tgt_delay + 1);
      if (e[104]) chk("R5/R6/R7 write lanes", c_wdata, e[63:32]);
      else        chk("R5/R6/R7 read lanes", rd, e[31:0]);
    end
    tgt_delay = 0;

    // R3: byte write at top of address port goes to legacy, register unchanged
    do_io(1, 16'h0CFB, 2'd0, 32'h0000_0001, rd, nreq, nlg, lat);
    chk("R3 legacy strobe", nlg, 1);
    chk("R3 legacy fields", {c_lwr, 13'b0, c_lsize, c_laddr}, {1'b1, 13'b0, 2'd0, 16'h0CFB});
    chk("R3 legacy wdata", c_lwdata, 32'h1);
    chk("R3 no target request", nreq, 0);
    do_io(0, 16'h0CF8, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R3 address reg unchanged", rd, 32'h8003_2944);
    do_io(0, 16'h0CFA, 2'd1, 0, rd, nreq, nlg, lat);
    chk("R3 legacy read data", rd, 32'hA1B2_C3D4);

    // R12: save, clobber, restore
    do_io(0, 16'h0CF8, 2'd2, 0, saved, nreq, nlg, lat);
    do_io(1, 16'h0CF8, 2'd2, 32'h8000_0800, rd, nreq, nlg, lat);
    do_io(1, 16'h0CF8, 2'd2, saved, rd, nreq, nlg, lat);
    do_io(0, 16'h0CF8, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R12 restored value", rd, 32'h8003_2944);
    do_io(0, 16'h0CFC, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R12 restored request fields", {10'b0, c_bus, c_devfn, c_reg}, {10'b0, 8'h03, 8'h29, 6'h11});

    // R10: enable clear
    do_io(1, 16'h0CF8, 2'd2, 32'h0003_2944, rd, nreq, nlg, lat);
    do_io(0, 16'h0CFC, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R10 disabled read value", rd, 32'hFFFF_FFFF);
    chk("R10 disabled read no request", nreq, 0);
    do_io(0, 16'h0CFD, 2'd0, 0, rd, nreq, nlg, lat);
    chk("R10 disabled byte read value", rd, 32'hFFFF_FFFF);
    do_io(1, 16'h0CFC, 2'd2, 32'hDEAD_BEEF, rd, nreq, nlg, lat);
    chk("R10 disabled write dropped", nreq, 0);

    // R11: misaligned with enable set
    do_io(1, 16'h0CF8, 2'd2, 32'h8003_2944, rd, nreq, nlg, lat);
    do_io(0, 16'h0CFD, 2'd1, 0, rd, nreq, nlg, lat);
    chk("R11 odd word read value", rd, 32'hFFFF_FFFF);
    chk("R11 odd word no request", nreq, 0);
    do_io(1, 16'h0CFE, 2'd2, 32'h5555_5555, rd, nreq, nlg, lat);
    chk("R11 offset dword write dropped", nreq, 0);

    // R9: long ack delay
    tgt_delay = 7;
    do_io(0, 16'h0CFC, 2'd2, 0, rd, nreq, nlg, lat);
    chk("R9 long delay latency", lat, 8);
    chk("R9 single request while waiting", nreq, 1);
    tgt_delay = 0;

    // R13: address outside the ports
    @(negedge clk);
    io_addr = 16'h0CF4; io_size = 2'd2; io_rd = 1'b1;
    nd = 0; nr = 0; nl = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (io_done) nd++;
      if (tgt_req) nr++;
      if (lg_req) nl++;
    end
    io_rd = 1'b0;
    chk("R13 no response outside ports", nd + nr + nl, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule